// File: doc/BRIEF.md
# Chainable Four-Channel DAC Serial Front End

This block is the digital front end of a four-channel digital-to-analog converter. A host holds an active-low load/select line low and clocks a 32-bit command word in, MSB first, on a serial data line. A serial clock carries the bits. When the load line returns high, the block decodes a command and a channel address from the word. It then updates per-channel input registers, DAC registers and power-down flags. Only the DAC register values and the power-down flags leave the block. The analog side that turns them into voltages is outside it.

The serial path is also a daisy-chain output. Every bit shifted in comes back out on the serial output 32 rising edges later, launched on a falling edge. Several devices can therefore share one clock and one load line, and all of them execute their own word on the same load edge. The serial clock, data and load inputs are sampled by a faster system clock, and their edges are detected in that clock domain. The inputs are assumed to be already synchronous to that clock.

Top module: `quad_dac_front`

## Requirements
- R1: After reset, every DAC register reads 0, every power-down flag reads 1, and the serial output is 0.
- R2: A bit is shifted in on each serial-clock rising edge while the load line is low. Rising edges while the load line is high shift nothing. The word is decoded on the load line's rising edge as follows: bits 31..24 don't care, bits 23..20 command, bits 19..16 address, bits 15..0 data field. Each DAC value is the top DAC_BITS bits of the data field.
- R3: Command 0000 writes the data into the input registers of the selected channels and leaves the DAC registers and power flags unchanged.
- R4: Command 0001 copies each selected channel's input register into its DAC register and clears that channel's power-down flag.
- R5: Command 0010 writes the data into the input registers of the selected channels. It then loads every DAC register from its input register and clears all four power-down flags.
- R6: Command 0011 writes the data into both the input register and the DAC register of the selected channels and clears their power-down flags.
- R7: Command 0100 sets the power-down flag of the selected channels. It ignores the data field and leaves the input and DAC register contents intact.
- R8: Command 1111, and every code other than 0000 to 0100, changes no register and no flag.
- R9: Addresses 0000 to 0011 select channels 0 to 3, and address 1111 selects all four channels. Any other address makes the command have no effect.
- R10: A bit shifted in on rising edge k appears on the serial output after the falling edge that follows rising edge k+31. In a longer frame only the last 32 bits are decoded, so the earlier bits pass through to the serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Active-low synchronous reset |
| sckIn | input | 1 | Serial clock |
| sdiIn | input | 1 | Serial data in, MSB first |
| csLdN | input | 1 | Active-low select; rising edge executes the word |
| sdoOut | output | 1 | Serial data out for chaining |
| dacFlat | output | 4*DAC_BITS | DAC register values, channel 0 in the least significant slice |
| pwrDown | output | 4 | Per-channel power-down flags, bit n for channel n |

## Verification
The hardest behaviour to reach from the ports is the pass-through of a chain. It needs a frame longer than 32 bits whose leading word is a real command. That word must leave on the serial output exactly one word later and must never be executed. The stimulus clocks 64 bits in one select window, with a write-and-update command first and a no-op last. It then compares every serial output sample with the leading word and checks that no register moved. Rising clock edges given while the select line is high are also exposed only through the serial output, so a frame of ones clocked with select high is followed by a normal frame whose serial output must stay all zero. A sweep over all sixteen commands and sixteen addresses follows, with an arithmetic model.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int NUM_CH  = 4;
  localparam int CMD_W   = 4;
  localparam int ADDR_W  = 4;
  localparam int FIELD_W = 16;
  localparam int PAD_W   = 8;
  localparam int HDR_W   = CMD_W + ADDR_W;
  localparam int WORD_W  = PAD_W + HDR_W + FIELD_W;

  typedef enum logic [CMD_W-1:0] {
    CMD_WR_IN      = 4'b0000,
    CMD_UPD        = 4'b0001,
    CMD_WR_UPD_ALL = 4'b0010,
    CMD_WR_UPD     = 4'b0011,
    CMD_PWR_DN     = 4'b0100,
    CMD_NOP        = 4'b1111
  } cmd_e;

  typedef struct packed {
    logic              shift;
    logic              launch;
    logic [NUM_CH-1:0] wrCh;
    logic [NUM_CH-1:0] updCh;
    logic [NUM_CH-1:0] pdCh;
  } strobe_t;
endpackage

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sckIn,
  input  logic             csLdN,
  input  logic [HDR_W-1:0] hdr,
  output strobe_t          st
);
  logic sckQ, csQ;
  logic loadEdge;
  logic [CMD_W-1:0]  cmd;
  logic [ADDR_W-1:0] addr;
  logic [NUM_CH-1:0] sel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckQ <= 1'b0;
      csQ  <= 1'b1;
    end else begin
      sckQ <= sckIn;
      csQ  <= csLdN;
    end
  end

  assign loadEdge = csLdN & ~csQ;
  assign cmd  = hdr[HDR_W-1 -: CMD_W];
  assign addr = hdr[ADDR_W-1:0];

  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      sel[k] = (addr == ADDR_W'(k)) || (addr == '1);
    end
  end

  always_comb begin
    st = '0;
    st.shift  = sckIn & ~sckQ & ~csLdN;
    st.launch = ~sckIn & sckQ;
    if (loadEdge && sel != '0) begin
      case (cmd)
        CMD_WR_IN: st.wrCh = sel;
        CMD_UPD:   st.updCh = sel;
        CMD_WR_UPD_ALL: begin
          st.wrCh  = sel;
          st.updCh = '1;
        end
        CMD_WR_UPD: begin
          st.wrCh  = sel;
          st.updCh = sel;
        end
        CMD_PWR_DN: st.pdCh = sel;
        default: ;
      endcase
    end
  end

  // R7: a channel is never powered down and updated by the same command
  assert_no_pd_with_upd_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.pdCh & st.updCh) == '0);

  // R2: register strobes only on a rising edge of the select line
  assert_strobe_on_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|{st.wrCh, st.updCh, st.pdCh}) |-> (csLdN && !$past(csLdN)));
endmodule

// File: rtl/qdac_datapath.sv
module qdac_datapath
  import qdac_pkg::*;
#(
  parameter int DAC_BITS = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sdiIn,
  input  strobe_t                    st,
  output logic [HDR_W-1:0]           hdr,
  output logic                       sdoOut,
  output logic [NUM_CH*DAC_BITS-1:0] dacFlat,
  output logic [NUM_CH-1:0]          pwrDown
);
  logic [WORD_W-1:0]   shiftReg;
  logic [DAC_BITS-1:0] fieldVal;
  logic                sdoReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdoReg   <= 1'b0;
    end else begin
      if (st.shift)  shiftReg <= {shiftReg[WORD_W-2:0], sdiIn};
      if (st.launch) sdoReg   <= shiftReg[WORD_W-1];
    end
  end

  assign hdr      = shiftReg[FIELD_W +: HDR_W];
  assign fieldVal = shiftReg[FIELD_W-1 -: DAC_BITS];
  assign sdoOut   = sdoReg;

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    logic [DAC_BITS-1:0] inReg, dacReg;
    logic                pdReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        inReg  <= '0;
        dacReg <= '0;
        pdReg  <= 1'b1;
      end else begin
        if (st.wrCh[c]) inReg <= fieldVal;
        if (st.updCh[c]) begin
          dacReg <= st.wrCh[c] ? fieldVal : inReg;
          pdReg  <= 1'b0;
        end else if (st.pdCh[c]) begin
          pdReg <= 1'b1;
        end
      end
    end

    assign dacFlat[c*DAC_BITS +: DAC_BITS] = dacReg;
    assign pwrDown[c] = pdReg;

    // R4: an updated channel is powered up on the next cycle
    assert_upd_powers_up_R4: assert property (@(posedge clk) disable iff (!rstN)
      st.updCh[c] |=> !pwrDown[c]);
  end

  // R7: power-down alone leaves the DAC values untouched
  assert_pd_keeps_values_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.pdCh != '0 && st.wrCh == '0 && st.updCh == '0) |=> $stable(dacFlat));

  // R8: with no register strobe, outputs hold
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrCh == '0 && st.updCh == '0 && st.pdCh == '0)
      |=> ($stable(dacFlat) && $stable(pwrDown)));

  // R10: serial output only moves after a serial-clock falling edge
  assert_sdo_on_fall_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sdoOut != $past(sdoOut)) |-> $past(st.launch));
endmodule

// File: rtl/quad_dac_front.sv
module quad_dac_front
  import qdac_pkg::*;
#(
  parameter int DAC_BITS = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sckIn,
  input  logic                       sdiIn,
  input  logic                       csLdN,
  output logic                       sdoOut,
  output logic [NUM_CH*DAC_BITS-1:0] dacFlat,
  output logic [NUM_CH-1:0]          pwrDown
);
  strobe_t          st;
  logic [HDR_W-1:0] hdr;

  qdac_ctrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .sckIn (sckIn),
    .csLdN (csLdN),
    .hdr   (hdr),
    .st    (st)
  );

  qdac_datapath #(.DAC_BITS(DAC_BITS)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .sdiIn   (sdiIn),
    .st      (st),
    .hdr     (hdr),
    .sdoOut  (sdoOut),
    .dacFlat (dacFlat),
    .pwrDown (pwrDown)
  );
endmodule

// File: tb/quad_dac_front_test.sv
`timescale 1ns/1ps
module quad_dac_front_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, sdiIn = 1'b0, csLdN = 1'b1;
  logic sdoOut;
  logic [63:0] dacFlat;
  logic [3:0]  pwrDown;

  int total = 0;
  int bad = 0;

  logic [15:0] mIn [4];
  logic [15:0] mDac [4];
  logic [3:0]  mPd;

  always #10 clk = ~clk;

  quad_dac_front uut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .sdiIn(sdiIn), .csLdN(csLdN),
    .sdoOut(sdoOut), .dacFlat(dacFlat), .pwrDown(pwrDown)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBit(input logic b, output logic seen);
    sdiIn = b;
    waitClk(2);
    sckIn = 1'b1;
    waitClk(3);
    sckIn = 1'b0;
    waitClk(3);
    seen = sdoOut;
  endtask

  task automatic sendBits(input int n, input logic [63:0] bits, input logic useCs,
                          output logic [63:0] seen);
    logic s;
    seen = '0;
    if (useCs) csLdN = 1'b0;
    waitClk(2);
    for (int i = 0; i < n; i++) begin
      clockBit(bits[n-1-i], s);
      seen[n-1-i] = s;
    end
    csLdN = 1'b1;
    waitClk(4);
  endtask

  function automatic logic [67:0] expState();
    return {mPd, mDac[3], mDac[2], mDac[1], mDac[0]};
  endfunction

  task automatic applyModel(input logic [3:0] cmd, input logic [3:0] addr, input logic [15:0] d);
    logic [3:0] sel;
    for (int k = 0; k < 4; k++) sel[k] = (addr == 4'(k)) || (addr == 4'hF);
    if (sel != 0) begin
      for (int k = 0; k < 4; k++) begin
        case (cmd)
          4'd0: if (sel[k]) mIn[k] = d;
          4'd1: if (sel[k]) begin mDac[k] = mIn[k]; mPd[k] = 1'b0; end
          4'd2: begin
            if (sel[k]) mIn[k] = d;
            mDac[k] = mIn[k];
            mPd[k] = 1'b0;
          end
          4'd3: if (sel[k]) begin mIn[k] = d; mDac[k] = d; mPd[k] = 1'b0; end
          4'd4: if (sel[k]) mPd[k] = 1'b1;
          default: ;
        endcase
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] seen;
    logic [31:0] wA, wB;
    string tag;
    for (int k = 0; k < 4; k++) begin mIn[k] = '0; mDac[k] = '0; end
    mPd = 4'hF;

    waitClk(4);
    rstN = 1'b1;
    waitClk(2);
    // R1: reset values
    chk("R1 reset dac/pd", {60'd0, pwrDown, dacFlat}, {60'd0, expState()});
    chk("R1 reset sdo", {127'd0, sdoOut}, 128'd0);

    // R2: ones clocked with select high must not enter the shift register
    sendBits(32, {32'd0, 32'hFFFF_FFFF}, 1'b0, seen);
    chk("R2 shift while deselected", {127'd0, sdoOut}, 128'd0);
    sendBits(32, {32'd0, 32'h00F0_0000}, 1'b1, seen);
    chk("R2 sdo stays low after deselected clocks", {96'd0, seen[31:0]}, 128'd0);
    chk("R8 nop frame leaves state", {60'd0, pwrDown, dacFlat}, {60'd0, expState()});

    // R10: 64-bit chain frame, leading word passes through and is not executed
    wA = 32'h0030_BEEF;
    wB = 32'h00F0_0000;
    sendBits(64, {wA, wB}, 1'b1, seen);
    chk("R10 pass-through word on sdo", {96'd0, seen[32:1]}, {96'd0, wA});
    chk("R10 leading word not executed", {60'd0, pwrDown, dacFlat}, {60'd0, expState()});

    // R3..R9: sweep every command and address against the model
    for (int c = 0; c < 16; c++) begin
      for (int a = 0; a < 16; a++) begin
        logic [15:0] d;
        d = 16'((c * 4369) ^ (a * 3855) ^ 42435 ^ (c * a * 97));
        sendBits(32, {32'd0, 8'hA5, 4'(c), 4'(a), d}, 1'b1, seen);
        applyModel(4'(c), 4'(a), d);
        case (c)
          0: tag = "R3 write input";
          1: tag = "R4 copy to dac";
          2: tag = "R5 write and update all";
          3: tag = "R6 write and update";
          4: tag = "R7 power down";
          default: tag = "R8 no-op code";
        endcase
        if (!(a < 4 || a == 15)) tag = "R9 ignored address";
        chk($sformatf("%s cmd=%0d addr=%0d", tag, c, a),
            {60'd0, pwrDown, dacFlat}, {60'd0, expState()});
      end
    end

    // R7: powered-down channels keep their values; R4 copy-all restores them
    sendBits(32, {32'd0, 32'h004F_1234}, 1'b1, seen);
    applyModel(4'h4, 4'hF, 16'h1234);
    chk("R7 power down all keeps values", {60'd0, pwrDown, dacFlat}, {60'd0, expState()});
    sendBits(32, {32'd0, 32'h001F_0000}, 1'b1, seen);
    applyModel(4'h1, 4'hF, 16'h0000);
    chk("R4 copy all after power down", {60'd0, pwrDown, dacFlat}, {60'd0, expState()});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule